// File: doc/BRIEF.md
# RTC Periodic Interrupt Generator

This block produces the periodic interrupt of a real-time clock. A sub-second divider counts tick enables from the oscillator domain and wraps once per second. The same divider supplies the 2 Hz and 1 Hz square waves. After each wrap, and a fixed delay, it issues a one-cycle seconds-increment strobe to an external calendar. The calendar answers with minute, hour and month rollover strobes in the same cycle as that strobe.

A 3-bit select field picks the pin behaviour:
- **Off:** the pin is held inactive.
- **Held low:** the pin is held active.
- **Pulse:** a free-running 50% duty waveform.
- **Level:** a latched interrupt that fires on second, minute, hour or month boundaries and stays active until the host clears it.

The interrupt output is active low. A companion flag reports the same interrupt state to the host. A write to the seconds register restarts the divider and cancels any increment still in flight.

Top module: `rtc_pint_gen`

## Requirements
- R1: With select 3'b000 the interrupt output is high, the flag is low, and both hold that state out of reset.
- R2: With select 3'b001 the interrupt output is held low.
- R3: With select 3'b010 the output is low during the first and third quarter of each divider period, and high during the second and fourth quarter (2 Hz, 50% duty).
- R4: With select 3'b011 the output is low during the first half of each divider period and high during the second half (1 Hz, 50% duty).
- R5: The divider advances on each cycle with the tick enable high and wraps after TICKS_PER_SEC ticks. The seconds-increment output pulses for exactly one cycle, starting INC_DELAY clock edges after the edge on which the divider wrapped.
- R6: A seconds write on a clock edge clears the divider to zero, ignores that cycle's tick and cancels a pending increment. In the pulse selects (3'b010, 3'b011) the output is therefore low in the following cycle.
- R7: In level mode the flag is high exactly when the interrupt output is low. Select 3'b100 sets the flag on the clock edge that ends each seconds-increment cycle.
- R8: Selects 3'b101, 3'b110 and 3'b111 set the flag only when the minute, hour or month rollover input, respectively, is high in the seconds-increment cycle.
- R9: A set level flag holds until a host clear. A clear releases the output high on the next edge. A set event in the same cycle as a clear wins.
- R10: A new select value takes effect on the next clock edge, and that edge clears any level flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 3 | Interrupt cycle select |
| tick_en_i | input | 1 | Sub-second tick enable |
| sec_wr_i | input | 1 | Seconds register write strobe |
| min_roll_i | input | 1 | Minute rollover from the calendar, valid with the increment strobe |
| hour_roll_i | input | 1 | Hour rollover from the calendar, valid with the increment strobe |
| month_roll_i | input | 1 | Month rollover from the calendar, valid with the increment strobe |
| flag_clr_i | input | 1 | Host clear of the level interrupt flag |
| int_n_o | output | 1 | Active-low interrupt output |
| flag_o | output | 1 | Interrupt state flag, high when the interrupt is active |
| sec_inc_o | output | 1 | One-cycle seconds-increment strobe to the calendar |

## Verification
Each result falls due at a known number of edges after its stimulus:
- **Waveform:** the pulse pin follows the divider in the cycle after the edge that advanced it.
- **Increment strobe:** it rises INC_DELAY edges after the wrap edge.
- **Level flag, clear and select change:** a level flag appears one edge after the strobe cycle that qualifies it. A clear or a select change shows one edge after it is driven.

The reference model updates on the rising edge from the inputs the bench drove on the preceding falling edge. Outputs are compared against it on every falling edge, so each comparison falls exactly one edge after the stimulus it reflects. Directed checks for a seconds write, a flag clear and a select change sample the first falling edge after the capturing rising edge.

// File: rtl/rtc_pint_pkg.sv
// Shared select encoding for the periodic interrupt generator.
// Assumes the 3-bit select field is decoded directly, bit 2 marking level modes.
package rtc_pint_pkg;

    typedef enum logic [2:0] {
        SEL_OFF   = 3'b000,
        SEL_LOW   = 3'b001,
        SEL_2HZ   = 3'b010,
        SEL_1HZ   = 3'b011,
        SEL_SEC   = 3'b100,
        SEL_MIN   = 3'b101,
        SEL_HOUR  = 3'b110,
        SEL_MONTH = 3'b111
    } pint_sel_e;

    // True for the four latched (level) modes.
    function automatic logic is_level(input pint_sel_e sel);
        return sel[2];
    endfunction

endpackage

// File: rtl/rtc_pint_div.sv
// Sub-second divider: counts tick enables and wraps once per second.
// Assumes TICKS_PER_SEC is a power of two of at least 4, so the top two
// count bits are the 1 Hz and 2 Hz square waves.
module rtc_pint_div #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en_i,
    input  logic clear_i,
    output logic wrap_o,
    output logic wave_1hz_o,
    output logic wave_2hz_o
);

    localparam int DIV_W = $clog2(TICKS_PER_SEC);
    localparam logic [DIV_W-1:0] LAST = DIV_W'(TICKS_PER_SEC - 1);

    logic [DIV_W-1:0] cnt_q;

    // A tick on the last count closes the second, unless a write restarts it.
    assign wrap_o = tick_en_i && (cnt_q == LAST) && !clear_i;

    // Count ticks; a seconds write forces the count back to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (tick_en_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign wave_1hz_o = cnt_q[DIV_W-1];
    assign wave_2hz_o = cnt_q[DIV_W-2];

endmodule

// File: rtl/rtc_pint_incdly.sv
// Seconds-increment delay: emits a one-cycle strobe INC_DELAY edges after
// the divider wraps. Assumes INC_DELAY >= 1 and shorter than one second.
module rtc_pint_incdly #(
    parameter int INC_DELAY = 23000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cancel_i,
    output logic strobe_o
);

    localparam int DLY_W = (INC_DELAY < 2) ? 1 : $clog2(INC_DELAY);
    localparam logic [DLY_W-1:0] LOAD = DLY_W'(INC_DELAY - 1);

    logic             pend_q;
    logic [DLY_W-1:0] dly_q;
    logic             strobe_q;

    // Run the delay after each wrap; a seconds write drops it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            dly_q    <= '0;
            strobe_q <= 1'b0;
        end else if (cancel_i) begin
            pend_q   <= 1'b0;
            dly_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= pend_q && (dly_q == '0);
            if (start_i) begin
                pend_q <= 1'b1;
                dly_q  <= LOAD;
            end else if (pend_q) begin
                if (dly_q == '0) begin
                    pend_q <= 1'b0;
                end else begin
                    dly_q <= dly_q - 1'b1;
                end
            end
        end
    end

    assign strobe_o = strobe_q;

endmodule

// File: rtl/rtc_pint_level.sv
// Level-mode interrupt latch: qualifies each seconds increment with the
// calendar rollover selected by the mode and holds the flag until cleared.
// Assumes rollover inputs are valid in the cycle the increment strobe is high.
module rtc_pint_level
    import rtc_pint_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pint_sel_e sel_i,
    input  logic      sel_chg_i,
    input  logic      sec_inc_i,
    input  logic      min_roll_i,
    input  logic      hour_roll_i,
    input  logic      month_roll_i,
    input  logic      clr_i,
    output logic      flag_o
);

    logic boundary_hit;
    logic set_evt;
    logic flag_q;

    // Pick the boundary that the current level mode waits for.
    always_comb begin
        case (sel_i)
            SEL_SEC:   boundary_hit = 1'b1;
            SEL_MIN:   boundary_hit = min_roll_i;
            SEL_HOUR:  boundary_hit = hour_roll_i;
            SEL_MONTH: boundary_hit = month_roll_i;
            default:   boundary_hit = 1'b0;
        endcase
    end

    assign set_evt = sec_inc_i && boundary_hit && is_level(sel_i);

    // Latch the flag; a mode change clears first, a new event beats a host clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (sel_chg_i) begin
            flag_q <= 1'b0;
        end else if (set_evt) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/rtc_pint_gen.sv
// Periodic interrupt generator top: registers the select field, runs the
// divider and increment delay, and muxes the interrupt output per mode.
// Assumes all inputs are synchronous to clk.
module rtc_pint_gen
    import rtc_pint_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int INC_DELAY     = 23000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel_i,
    input  logic       tick_en_i,
    input  logic       sec_wr_i,
    input  logic       min_roll_i,
    input  logic       hour_roll_i,
    input  logic       month_roll_i,
    input  logic       flag_clr_i,
    output logic       int_n_o,
    output logic       flag_o,
    output logic       sec_inc_o
);

    pint_sel_e sel_q;
    logic      sel_chg;
    logic      wrap;
    logic      wave_1hz;
    logic      wave_2hz;
    logic      sec_inc;
    logic      lvl_flag;
    logic      irq_act;

    // Adopt the select field one edge after it is driven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SEL_OFF;
        end else begin
            sel_q <= pint_sel_e'(sel_i);
        end
    end

    assign sel_chg = (pint_sel_e'(sel_i) != sel_q);

    rtc_pint_div #(
        .TICKS_PER_SEC(TICKS_PER_SEC)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en_i (tick_en_i),
        .clear_i   (sec_wr_i),
        .wrap_o    (wrap),
        .wave_1hz_o(wave_1hz),
        .wave_2hz_o(wave_2hz)
    );

    rtc_pint_incdly #(
        .INC_DELAY(INC_DELAY)
    ) u_incdly (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (wrap),
        .cancel_i(sec_wr_i),
        .strobe_o(sec_inc)
    );

    rtc_pint_level u_level (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel_q),
        .sel_chg_i   (sel_chg),
        .sec_inc_i   (sec_inc),
        .min_roll_i  (min_roll_i),
        .hour_roll_i (hour_roll_i),
        .month_roll_i(month_roll_i),
        .clr_i       (flag_clr_i),
        .flag_o      (lvl_flag)
    );

    // Choose the active interrupt state for the adopted mode.
    always_comb begin
        case (sel_q)
            SEL_OFF: irq_act = 1'b0;
            SEL_LOW: irq_act = 1'b1;
            SEL_2HZ: irq_act = !wave_2hz;
            SEL_1HZ: irq_act = !wave_1hz;
            default: irq_act = lvl_flag;
        endcase
    end

    assign int_n_o   = !irq_act;
    assign flag_o    = irq_act;
    assign sec_inc_o = sec_inc;

endmodule

// File: rtl/rtc_pint_gen_chk.sv
// Property checker for the periodic interrupt generator, bound to the top.
module rtc_pint_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] sel_i,
    input logic       sec_wr_i,
    input logic       flag_clr_i,
    input logic [2:0] sel_q,
    input logic       int_n_o,
    input logic       flag_o,
    input logic       sec_inc_o
);

    logic past_ok;

    // Marks cycles whose previous edge was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r1_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(sel_i) == 3'b000) |-> int_n_o && !flag_o);

    a_r2_fixed_low: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(sel_i) == 3'b001) |-> !int_n_o);

    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        sec_inc_o |=> !sec_inc_o);

    a_r6_write_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr_i && ((sel_i == 3'b010) || (sel_i == 3'b011)) |=> !int_n_o && !sec_inc_o);

    a_r7_second_event: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 3'b100) && (sel_i == sel_q) && sec_inc_o |=> !int_n_o && flag_o);

    a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q[2] && (sel_i == sel_q) && !int_n_o && !flag_clr_i |=> !int_n_o);

    a_r10_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i != sel_q) && sel_i[2] |=> int_n_o);

endmodule

bind rtc_pint_gen rtc_pint_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel_i),
    .sec_wr_i  (sec_wr_i),
    .flag_clr_i(flag_clr_i),
    .sel_q     (sel_q),
    .int_n_o   (int_n_o),
    .flag_o    (flag_o),
    .sec_inc_o (sec_inc_o)
);

// File: tb/rtc_pint_gen_tb_top.sv
// Bench: behavioural reference model compared on every falling edge,
// plus directed checks for write, clear and select change.
module rtc_pint_gen_tb_top;

    localparam int T = 16;
    localparam int D = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] sel_i;
    logic       tick_en_i, sec_wr_i, min_roll_i, hour_roll_i, month_roll_i, flag_clr_i;
    logic       int_n_o, flag_o, sec_inc_o;

    always #2 clk = ~clk;

    rtc_pint_gen #(
        .TICKS_PER_SEC(T),
        .INC_DELAY    (D)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel_i),
        .tick_en_i   (tick_en_i),
        .sec_wr_i    (sec_wr_i),
        .min_roll_i  (min_roll_i),
        .hour_roll_i (hour_roll_i),
        .month_roll_i(month_roll_i),
        .flag_clr_i  (flag_clr_i),
        .int_n_o     (int_n_o),
        .flag_o      (flag_o),
        .sec_inc_o   (sec_inc_o)
    );

    int         checks = 0;
    int         errors = 0;
    int         wd = 0;
    string      cur_req = "R1";
    bit         chk_en = 1'b0;
    bit         done = 1'b0;
    int         tick_mode = 0;
    bit         clr_auto = 1'b0;
    logic [7:0] lfsr = 8'h5a;

    // Reference model state
    int         m_cnt, m_dly;
    bit         m_pend, m_inc, m_flag, m_wrap, m_hit, m_next_inc;
    logic [2:0] m_sel;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_dly = 0; m_pend = 0; m_inc = 0; m_flag = 0; m_sel = 3'b000;
        end else begin
            m_wrap = tick_en_i && (m_cnt == T - 1);
            case (m_sel)
                3'd4:    m_hit = 1'b1;
                3'd5:    m_hit = min_roll_i;
                3'd6:    m_hit = hour_roll_i;
                3'd7:    m_hit = month_roll_i;
                default: m_hit = 1'b0;
            endcase
            if (sel_i != m_sel)       m_flag = 1'b0;
            else if (m_inc && m_hit)  m_flag = 1'b1;
            else if (flag_clr_i)      m_flag = 1'b0;
            if (sec_wr_i) begin
                m_cnt = 0; m_pend = 0; m_dly = 0; m_inc = 0;
            end else begin
                m_next_inc = m_pend && (m_dly == 0);
                if (m_wrap) begin
                    m_pend = 1'b1; m_dly = D - 1;
                end else if (m_pend) begin
                    if (m_dly == 0) m_pend = 1'b0;
                    else            m_dly = m_dly - 1;
                end
                if (tick_en_i) m_cnt = (m_cnt + 1) % T;
                m_inc = m_next_inc;
            end
            m_sel = sel_i;
        end
    end

    function automatic bit exp_irq();
        case (m_sel)
            3'd0:    return 1'b0;
            3'd1:    return 1'b1;
            3'd2:    return ((m_cnt / (T / 4)) % 2) == 0;
            3'd3:    return (m_cnt / (T / 2)) == 0;
            default: return m_flag;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_en) begin
            chk(cur_req, "int_n_o", int_n_o, !exp_irq());
            chk("R7", "flag_o", flag_o, exp_irq());
            chk("R5", "sec_inc_o", sec_inc_o, m_inc);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL R5 watchdog actual=%0d expected<=%0d", wd, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // One cycle: wait a falling edge, then drive the background inputs
    task automatic cyc();
        @(negedge clk);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (tick_mode)
            0:       tick_en_i = 1'b1;
            1:       tick_en_i = ~tick_en_i;
            default: tick_en_i = lfsr[0];
        endcase
        min_roll_i   = lfsr[1];
        hour_roll_i  = lfsr[1] & lfsr[3];
        month_roll_i = lfsr[1] & lfsr[3] & lfsr[5];
        flag_clr_i   = clr_auto && (lfsr[6:4] == 3'b000);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wait_pin(input logic val);
        for (int i = 0; i < 64 && int_n_o !== val; i++) cyc();
    endtask

    initial begin
        rst_n = 1'b0; sel_i = 3'b000; tick_en_i = 1'b0; sec_wr_i = 1'b0;
        min_roll_i = 1'b0; hour_roll_i = 1'b0; month_roll_i = 1'b0; flag_clr_i = 1'b0;
        run(4);
        // R1: reset state
        chk("R1", "reset int_n_o", int_n_o, 1'b1);
        chk("R1", "reset flag_o", flag_o, 1'b0);
        chk("R1", "reset sec_inc_o", sec_inc_o, 1'b0);
        rst_n = 1'b1;
        chk_en = 1'b1;

        cur_req = "R1"; sel_i = 3'b000; tick_mode = 0; run(40);
        cur_req = "R2"; sel_i = 3'b001; run(20);
        cur_req = "R3"; sel_i = 3'b010; run(80);
        cur_req = "R4"; sel_i = 3'b011; tick_mode = 1; run(100);
        cur_req = "R5"; tick_mode = 2; run(200);

        // R6: write mid-second while the 1 Hz pin is high
        cur_req = "R6"; tick_mode = 0; sel_i = 3'b011;
        wait_pin(1'b1);
        sec_wr_i = 1'b1;
        cyc();
        sec_wr_i = 1'b0;
        chk("R6", "pin low after write", int_n_o, 1'b0);
        chk("R6", "no strobe after write", sec_inc_o, 1'b0);
        run(60);

        cur_req = "R7"; sel_i = 3'b100; clr_auto = 1'b1; run(200);
        cur_req = "R8"; sel_i = 3'b101; run(300);
        sel_i = 3'b110; run(300);
        sel_i = 3'b111; run(400);

        // R9: hold until cleared, then release
        cur_req = "R9"; clr_auto = 1'b0; sel_i = 3'b100;
        run(2);
        wait_pin(1'b0);
        run(5);
        chk("R9", "flag held", int_n_o, 1'b0);
        flag_clr_i = 1'b1;
        @(negedge clk);
        flag_clr_i = 1'b0;
        chk("R9", "released by clear", int_n_o, 1'b1);
        run(40);

        // R10: select change clears a pending flag
        cur_req = "R10"; sel_i = 3'b100;
        wait_pin(1'b0);
        sel_i = 3'b101;
        @(negedge clk);
        chk("R10", "cleared on change", int_n_o, 1'b1);
        run(50);

        chk_en = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule